// File: doc/BRIEF.md
# Trace Message Queue with Overflow Reporting

This block collects debug trace messages from three producers (watchpoint hits, ownership changes and data accesses) and holds them in a small first-in first-out store until the downstream port logic takes them. Each producer offers one message at a time over a valid/ready handshake. When more than one producer offers in the same cycle, a fixed priority decides which message is stored first. The others keep their offer up until they are taken.

When the store is full, an offered message cannot be kept. That refusal opens an overflow episode. For the whole episode the block takes in every offered message and drops it, and it records which producer types lost messages. The episode lasts until the store has drained completely, not just until one slot frees. In the cycle the store becomes empty, the block writes one error entry whose code summarises the lost types. It also raises a one-cycle overrun flag, which downstream synchronisation logic uses to restart its message framing.

A doubleword data access travels as a single entry with one 64-bit value; the payload field is wide enough for the longest message.

Top module: `trace_queue`

## Requirements
- R1: After reset the output stream is idle (`q_valid` low) and `overrun` is low.
- R2: In normal operation only one offer is accepted per cycle, chosen by fixed priority: watchpoint, then ownership, then data. A losing producer sees its ready low and keeps its offer.
- R3: Accepted messages leave in acceptance order, with payload, length and kind intact. The kind codes are: 0 data, 1 ownership, 2 watchpoint, 3 error. A 64-bit doubleword value is stored as one entry.
- R4: An offer made while the store holds DEPTH entries is consumed (ready high) but not stored, and it opens an overflow episode.
- R5: During an episode every offer is consumed and dropped, including offers made after slots have freed, until the store is empty.
- R6: In the cycle the store is empty during an episode, one error entry is written. It has kind 3, length ERR_LEN, the error code in payload bits [4:0] and zeros in all other payload bits. It is visible at the output in the next cycle.
- R7: The error code is 5'b01000 if any watchpoint message was lost. If none was, it is 5'b00111 if any ownership message was lost. Otherwise it is 5'b00010, meaning only data messages were lost.
- R8: `overrun` is high for exactly one cycle per error entry, in the first cycle that entry is at the head of the output.
- R9: In the cycle after the error entry is written, offers are accepted and stored normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_valid | input | 1 | Watchpoint message offered |
| wp_ready | output | 1 | Watchpoint offer taken this cycle |
| wp_data | input | PAY_W | Watchpoint payload |
| wp_len | input | LEN_W | Watchpoint message length |
| ot_valid | input | 1 | Ownership message offered |
| ot_ready | output | 1 | Ownership offer taken this cycle |
| ot_data | input | PAY_W | Ownership payload |
| ot_len | input | LEN_W | Ownership message length |
| dt_valid | input | 1 | Data trace message offered |
| dt_ready | output | 1 | Data trace offer taken this cycle |
| dt_data | input | PAY_W | Data trace payload |
| dt_len | input | LEN_W | Data trace message length |
| q_valid | output | 1 | Head entry available |
| q_ready | input | 1 | Downstream takes the head entry |
| q_data | output | PAY_W | Head payload |
| q_len | output | LEN_W | Head length |
| q_kind | output | 2 | Head kind (0 data, 1 ownership, 2 watchpoint, 3 error) |
| overrun | output | 1 | One-cycle pulse when an error entry reaches the head |

## Verification
The bench builds the queue with DEPTH=4, the full 109-bit payload, a 7-bit length and ERR_LEN=15. The shallow depth lets a few offers fill the store, so each loss pattern can be driven from its own fresh episode. These episodes include a slot freed mid-drain, and each pattern's code and overrun pulse is checked. The full payload width lets a 64-bit doubleword and the error code field be compared bit for bit.

// File: rtl/trq_pkg.sv
package trq_pkg;
  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_OWN  = 2'd1,
    K_WP   = 2'd2,
    K_ERR  = 2'd3
  } trq_kind_e;

  // source index order equals priority order
  localparam int SRC_WP  = 0;
  localparam int SRC_OWN = 1;
  localparam int SRC_DT  = 2;
  localparam int NSRC    = 3;

  localparam logic [4:0] CODE_DT_ONLY = 5'b00010;
  localparam logic [4:0] CODE_OWN     = 5'b00111;
  localparam logic [4:0] CODE_WP      = 5'b01000;

  function automatic logic [4:0] loss_code(input logic [NSRC-1:0] lost);
    if (lost[SRC_WP])       return CODE_WP;
    else if (lost[SRC_OWN]) return CODE_OWN;
    else                    return CODE_DT_ONLY;
  endfunction
endpackage

// File: rtl/trq_arbiter.sv
module trq_arbiter #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         discard,
  output logic [N-1:0] grant,
  output logic [N-1:0] ready,
  output logic         accept
);
  logic [N:0] seen;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pri
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate
  assign seen[0] = 1'b0;

  // while discarding every offer is swallowed; otherwise only the winner
  assign ready  = discard ? req : grant;
  assign accept = ~discard & (|req);

  assert_one_winner_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_top_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (!discard && req[0]) |-> (ready[0] && $countones(ready) == 1));
endmodule

// File: rtl/trq_fifo.sv
module trq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 118
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/trq_drain_ctl.sv
module trq_drain_ctl
  import trq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            full,
  input  logic            empty,
  input  logic [NSRC-1:0] req,
  output logic            discard,
  output logic            err_push,
  output logic [4:0]      err_code,
  output logic            overrun
);
  logic            drain_q;
  logic [NSRC-1:0] lost_q, refused, lost_all;

  assign discard  = drain_q | full;
  assign refused  = discard ? req : '0;
  assign lost_all = lost_q | refused;
  assign err_push = drain_q & empty;
  assign err_code = loss_code(lost_all);

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q <= 1'b0;
      lost_q  <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= err_push;
      if (err_push) begin
        drain_q <= 1'b0;
        lost_q  <= '0;
      end else if (|refused) begin
        drain_q <= 1'b1;
        lost_q  <= lost_all;
      end
    end
  end

  assert_drain_until_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (drain_q && !empty) |=> drain_q);
  assert_loss_recorded_R7: assert property (@(posedge clk) disable iff (rst)
    err_push |-> (lost_all != '0));
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> !overrun);
endmodule

// File: rtl/trace_queue.sv
module trace_queue
  import trq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int PAY_W   = 109,
  parameter int LEN_W   = 7,
  parameter int ERR_LEN = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wp_valid,
  output logic             wp_ready,
  input  logic [PAY_W-1:0] wp_data,
  input  logic [LEN_W-1:0] wp_len,
  input  logic             ot_valid,
  output logic             ot_ready,
  input  logic [PAY_W-1:0] ot_data,
  input  logic [LEN_W-1:0] ot_len,
  input  logic             dt_valid,
  output logic             dt_ready,
  input  logic [PAY_W-1:0] dt_data,
  input  logic [LEN_W-1:0] dt_len,
  output logic             q_valid,
  input  logic             q_ready,
  output logic [PAY_W-1:0] q_data,
  output logic [LEN_W-1:0] q_len,
  output logic [1:0]       q_kind,
  output logic             overrun
);
  localparam int EW = 2 + LEN_W + PAY_W;

  logic [NSRC-1:0] req, grant, ready;
  logic            accept, discard, err_push, full, empty, pop, push;
  logic [4:0]      err_code;
  logic [EW-1:0]   din, dout;

  assign req = {dt_valid, ot_valid, wp_valid};

  trq_drain_ctl u_ctl (
    .clk(clk), .rst(rst), .full(full), .empty(empty), .req(req),
    .discard(discard), .err_push(err_push), .err_code(err_code),
    .overrun(overrun)
  );

  trq_arbiter #(.N(NSRC)) u_arb (
    .clk(clk), .rst(rst), .req(req), .discard(discard),
    .grant(grant), .ready(ready), .accept(accept)
  );

  always_comb begin
    if (err_push)
      din = {K_ERR, LEN_W'(ERR_LEN), {(PAY_W-5){1'b0}}, err_code};
    else if (grant[SRC_WP])
      din = {K_WP, wp_len, wp_data};
    else if (grant[SRC_OWN])
      din = {K_OWN, ot_len, ot_data};
    else
      din = {K_DATA, dt_len, dt_data};
  end

  assign push = accept | err_push;
  assign pop  = q_valid & q_ready;

  trq_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(din), .pop(pop),
    .dout(dout), .full(full), .empty(empty)
  );

  assign wp_ready = ready[SRC_WP];
  assign ot_ready = ready[SRC_OWN];
  assign dt_ready = ready[SRC_DT];
  assign q_valid  = ~empty;
  assign {q_kind, q_len, q_data} = dout;

  assert_err_at_head_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |-> (q_valid && q_kind == K_ERR));
  assert_err_into_empty_R6: assert property (@(posedge clk) disable iff (rst)
    err_push |-> !accept);
endmodule

// File: tb/trace_queue_test.sv
module trace_queue_test;
  localparam int DEPTH = 4, PAY_W = 109, LEN_W = 7, ERR_LEN = 15;
  localparam int EW = 2 + LEN_W + PAY_W;

  logic clk = 1'b0, rst = 1'b1;
  logic wp_valid = 0, ot_valid = 0, dt_valid = 0, q_ready = 0;
  logic [PAY_W-1:0] wp_data = '0, ot_data = '0, dt_data = '0;
  logic [LEN_W-1:0] wp_len = '0, ot_len = '0, dt_len = '0;
  logic wp_ready, ot_ready, dt_ready, q_valid, overrun;
  logic [PAY_W-1:0] q_data;
  logic [LEN_W-1:0] q_len;
  logic [1:0] q_kind;

  logic [EW-1:0] exp_q[$];
  int checks = 0, errors = 0, ovr_seen = 0, err_expected = 0;
  logic ovr_prev = 1'b0;

  always #5 clk = ~clk;

  trace_queue #(.DEPTH(DEPTH), .PAY_W(PAY_W), .LEN_W(LEN_W), .ERR_LEN(ERR_LEN)) uut (
    .clk(clk), .rst(rst),
    .wp_valid(wp_valid), .wp_ready(wp_ready), .wp_data(wp_data), .wp_len(wp_len),
    .ot_valid(ot_valid), .ot_ready(ot_ready), .ot_data(ot_data), .ot_len(ot_len),
    .dt_valid(dt_valid), .dt_ready(dt_ready), .dt_data(dt_data), .dt_len(dt_len),
    .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data), .q_len(q_len),
    .q_kind(q_kind), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit rdy(input int s);
    return (s == 0) ? wp_ready : (s == 1) ? ot_ready : dt_ready;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (overrun) begin
        ovr_seen++;
        chk(!ovr_prev, "R8", "overrun longer than one cycle", EW'(1), EW'(0));
        chk(q_valid && q_kind == 2'd3, "R8", "overrun without error at head",
            EW'(q_kind), EW'(3));
      end
      ovr_prev = overrun;
      if (q_valid && q_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R3", "unexpected entry", {q_kind, q_len, q_data}, '0);
        else begin
          logic [EW-1:0] e;
          e = exp_q.pop_front();
          chk({q_kind, q_len, q_data} == e, (e[EW-1 -: 2] == 2'd3) ? "R6/R7" : "R3",
              "head entry", {q_kind, q_len, q_data}, e);
        end
      end
    end
  end

  // offer one message; store=1 means it should be kept in the queue
  task automatic offer(input int src, input logic [PAY_W-1:0] d,
                       input logic [LEN_W-1:0] l, input bit store,
                       input bit instant, input string req);
    logic [1:0] k;
    @(negedge clk);
    case (src)
      0: begin wp_valid = 1; wp_data = d; wp_len = l; k = 2'd2; end
      1: begin ot_valid = 1; ot_data = d; ot_len = l; k = 2'd1; end
      default: begin dt_valid = 1; dt_data = d; dt_len = l; k = 2'd0; end
    endcase
    #1;
    if (instant) chk(rdy(src), req, "ready not high at once", EW'(rdy(src)), EW'(1));
    while (!rdy(src)) begin @(negedge clk); #1; end
    if (store) exp_q.push_back({k, l, d});
    @(posedge clk); #1;
    case (src)
      0: wp_valid = 0;
      1: ot_valid = 0;
      default: dt_valid = 0;
    endcase
  endtask

  task automatic set_qready(input bit v);
    @(posedge clk); #1; q_ready = v;
  endtask

  task automatic wait_empty();
    int n;
    n = 0;
    while ((exp_q.size() != 0 || q_valid) && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  // drive one overflow episode; lose: bit0 wp, bit1 ownership, bit2 data
  task automatic episode(input logic [2:0] lose, input logic [4:0] code, input string req);
    int late;
    set_qready(0);
    for (int i = 0; i < DEPTH; i++)
      offer(2, PAY_W'(64'hA000 + i + 16 * lose), LEN_W'(20 + i), 1, 0, "R3");
    for (int s = 0; s < 3; s++)
      if (lose[s]) offer(s, PAY_W'(64'hDEAD), LEN_W'(9), 0, 1, "R4");
    set_qready(1);
    set_qready(0);
    late = lose[2] ? 2 : (lose[1] ? 1 : 0);
    offer(late, PAY_W'(64'hBEEF), LEN_W'(9), 0, 1, "R5");
    exp_q.push_back({2'd3, LEN_W'(ERR_LEN), PAY_W'(code)});
    err_expected++;
    set_qready(1);
    wait_empty();
    chk(1'b1, req, "episode", '0, '0);
    // R9: normal acceptance right after recovery
    offer(2, PAY_W'(64'h5A5A), LEN_W'(33), 1, 1, "R9");
    wait_empty();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL all: watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!q_valid, "R1", "q_valid after reset", EW'(q_valid), '0);
    chk(!overrun, "R1", "overrun after reset", EW'(overrun), '0);

    // R2: simultaneous offers, queue not draining
    fork
      offer(0, PAY_W'(64'h111), LEN_W'(11), 1, 0, "R2");
      offer(1, PAY_W'(64'h222), LEN_W'(12), 1, 0, "R2");
      offer(2, PAY_W'(64'h333), LEN_W'(13), 1, 0, "R2");
      begin
        @(negedge clk); #2;
        chk(wp_ready && !ot_ready && !dt_ready, "R2", "only watchpoint ready",
            EW'({dt_ready, ot_ready, wp_ready}), EW'(3'b001));
        @(negedge clk); #2;
        chk(ot_ready && !dt_ready && dt_valid, "R2", "ownership next, data held",
            EW'({dt_valid, dt_ready, ot_ready}), EW'(3'b101));
      end
    join
    set_qready(1);
    wait_empty();

    // R3: streaming data, including a 64-bit doubleword value
    offer(2, PAY_W'(64'hFEDC_BA98_7654_3210), LEN_W'(109), 1, 1, "R3");
    offer(1, {PAY_W{1'b1}}, LEN_W'(15), 1, 1, "R3");
    offer(2, PAY_W'(64'h1), LEN_W'(47), 1, 1, "R3");
    wait_empty();

    episode(3'b100, 5'b00010, "R7");
    episode(3'b110, 5'b00111, "R7");
    episode(3'b010, 5'b00111, "R7");
    episode(3'b111, 5'b01000, "R7");
    episode(3'b001, 5'b01000, "R7");

    chk(exp_q.size() == 0, "R3", "entries missing", EW'(exp_q.size()), '0);
    chk(ovr_seen == err_expected, "R8", "overrun pulse count",
        EW'(ovr_seen), EW'(err_expected));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule